// File: doc/BRIEF.md
# Transmit Configuration Holder with Inter-Frame Gap Timer

This block keeps the configuration word of an Ethernet transmitter and decides when the transmit datapath may start the next frame. Software writes the word over a simple strobe-based register port. A write never disturbs a frame that is on the wire. The new value is parked in a staging copy and moved into the active configuration only once the datapath reports that no frame is in progress. The one exception is the reset bit. Writing it acts on the same clock edge: the staging and active copies both return to their defaults, any parked write is dropped, and a one-cycle reset pulse is sent to the transmitter.

The block also times the idle gap that must follow every frame. While the datapath's frame-active input is high, a down-counter is loaded with the gap length. Once the frame ends, the counter runs out one idle cycle at a time. The start-permission output is raised only when the counter is empty, no frame is active, and transmission is enabled in the active configuration. The gap normally lasts the 12-cycle minimum. When the gap-extension field is set, the gap is the larger of 12 and a programmed extension value.

No data stream passes through this block. Every pin is a plain control or status level, and none of them has a handshake.

Top module: `txcfg_gap_ctrl`

## Requirements
- R1: After `rst_n` is released, the active outputs are transmit enable = 1 and jumbo, in-band FCS and VLAN = 0. `tx_rst_pulse` is 0, `tx_ready` is 1 while `frame_active` is 0, and a read returns 32'h1000_0000.
- R2: A write accepted while `frame_active` is 1 leaves the active outputs unchanged for as long as `frame_active` stays 1. The new values appear one cycle after the first clock edge that samples `frame_active` low.
- R3: A write accepted while `frame_active` is 0 reaches the active outputs after the second rising edge counted from the edge that samples the write.
- R4: When two writes are accepted before the apply point, only the later one takes effect.
- R5: Writing bit 31 = 1 acts at the edge that samples the write, even during a frame. At that edge the active and staged configuration return to their defaults, any pending write is discarded, and `tx_rst_pulse` is high for exactly the following cycle. Bit 31 always reads back as 0.
- R6: The register word has these fields: bit 30 jumbo, bit 29 in-band FCS, bit 28 transmit enable, bit 27 VLAN, bit 26 half-duplex, bit 25 gap extension, and bit 22 in-line command. Bits 24:23 and 21:0 read as 0 whatever was written.
- R7: A read strobe sampled at an edge puts the most recently written word (not the active configuration) on `reg_rdata` in the cycle after that edge. `reg_rdata` holds its value until the next read.
- R8: With gap extension at 0, `tx_ready` stays low for exactly 12 idle cycles after `frame_active` falls and rises in the 13th.
- R9: With gap extension at 1, the gap is max(12, `ifg_ext`) idle cycles. `ifg_ext` is taken on the last cycle of the frame.
- R10: While the active transmit enable is 0, `tx_ready` stays 0.
- R11: `tx_ready` is 0 in every cycle in which `frame_active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Registered read data |
| frame_active | input | 1 | High while the datapath is sending a frame |
| ifg_ext | input | IFG_W | Programmed gap extension in idle cycles |
| cfg_tx_en | output | 1 | Active transmit enable |
| cfg_jumbo | output | 1 | Active jumbo-frame enable |
| cfg_fcs_in | output | 1 | Active in-band FCS enable |
| cfg_vlan | output | 1 | Active VLAN enable |
| tx_rst_pulse | output | 1 | One-cycle transmitter reset |
| tx_ready | output | 1 | Permission to start the next frame |

## Verification
Results arrive at different delays:
- A write sampled at an idle edge is visible after one further edge.
- A write sampled mid-frame is visible one cycle after the first edge that sees `frame_active` low.
- The reset pulse and the restored defaults appear right after the edge that samples the write.
- Read data appears one cycle after the read edge.

The bench drives inputs on the falling edge and samples one time unit later, at the exact cycle where each result is due. It also checks the cycle just before, so that an early result is caught as well as a late one. Gap length is measured by counting the falling edges on which `tx_ready` is still low after the frame ends.

// File: rtl/txcfg_pkg.sv
package txcfg_pkg;

  localparam int unsigned REG_W      = 32;
  // Bit positions software decodes
  localparam int unsigned BIT_RST    = 31;
  localparam int unsigned BIT_JUMBO  = 30;
  localparam int unsigned BIT_FCS    = 29;
  localparam int unsigned BIT_EN     = 28;
  localparam int unsigned BIT_VLAN   = 27;
  localparam int unsigned BIT_HDX    = 26;
  localparam int unsigned BIT_GAPX   = 25;
  localparam int unsigned BIT_INLINE = 22;

  // Bits that never hold state
  localparam logic [REG_W-1:0] RSVD_MASK = 32'h01BF_FFFF;

  // Staged copy: every writable field
  typedef struct packed {
    logic jumbo;
    logic fcs_in;
    logic en;
    logic vlan;
    logic hdx;
    logic gapx;
    logic inline_cmd;
  } txcfg_stage_t;

  // Active copy: fields that steer hardware
  typedef struct packed {
    logic jumbo;
    logic fcs_in;
    logic en;
    logic vlan;
    logic gapx;
  } txcfg_act_t;

  localparam txcfg_stage_t STAGE_DEF = '{jumbo: 1'b0, fcs_in: 1'b0, en: 1'b1,
                                         vlan: 1'b0, hdx: 1'b0, gapx: 1'b0,
                                         inline_cmd: 1'b0};
  localparam txcfg_act_t   ACT_DEF   = '{jumbo: 1'b0, fcs_in: 1'b0, en: 1'b1,
                                         vlan: 1'b0, gapx: 1'b0};

  function automatic txcfg_stage_t word_to_stage(input logic [REG_W-1:0] w);
    txcfg_stage_t s;
    s.jumbo      = w[BIT_JUMBO];
    s.fcs_in     = w[BIT_FCS];
    s.en         = w[BIT_EN];
    s.vlan       = w[BIT_VLAN];
    s.hdx        = w[BIT_HDX];
    s.gapx       = w[BIT_GAPX];
    s.inline_cmd = w[BIT_INLINE];
    return s;
  endfunction

  function automatic logic [REG_W-1:0] stage_to_word(input txcfg_stage_t s);
    logic [REG_W-1:0] w;
    w             = '0;
    w[BIT_JUMBO]  = s.jumbo;
    w[BIT_FCS]    = s.fcs_in;
    w[BIT_EN]     = s.en;
    w[BIT_VLAN]   = s.vlan;
    w[BIT_HDX]    = s.hdx;
    w[BIT_GAPX]   = s.gapx;
    w[BIT_INLINE] = s.inline_cmd;
    return w;
  endfunction

  function automatic txcfg_act_t stage_to_act(input txcfg_stage_t s);
    txcfg_act_t a;
    a.jumbo  = s.jumbo;
    a.fcs_in = s.fcs_in;
    a.en     = s.en;
    a.vlan   = s.vlan;
    a.gapx   = s.gapx;
    return a;
  endfunction

endpackage

// File: rtl/txcfg_regs.sv
module txcfg_regs
  import txcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             rd_en,
  input  logic             frame_active,
  output logic [REG_W-1:0] rdata,
  output txcfg_act_t       active,
  output logic             soft_rst_now,
  output logic             soft_rst_pulse
);

  txcfg_stage_t stage_q;
  txcfg_act_t   active_q;
  logic         pend_q;
  logic         apply_now;
  logic         unused_rsvd;

  // Reserved write bits are dropped
  assign unused_rsvd  = ^(wdata & RSVD_MASK);

  assign soft_rst_now = wr_en && wdata[BIT_RST];
  assign apply_now    = pend_q && !frame_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q        <= STAGE_DEF;
      active_q       <= ACT_DEF;
      pend_q         <= 1'b0;
      soft_rst_pulse <= 1'b0;
      rdata          <= '0;
    end else begin
      soft_rst_pulse <= soft_rst_now;
      if (rd_en) begin
        rdata <= stage_to_word(stage_q);
      end
      if (soft_rst_now) begin
        // Immediate: discard anything pending
        stage_q  <= STAGE_DEF;
        active_q <= ACT_DEF;
        pend_q   <= 1'b0;
      end else begin
        if (apply_now) begin
          active_q <= stage_to_act(stage_q);
        end
        if (wr_en) begin
          stage_q <= word_to_stage(wdata);
          pend_q  <= 1'b1;
        end else if (apply_now) begin
          pend_q  <= 1'b0;
        end
      end
    end
  end

  assign active = active_q;

  // R2: nothing moves the active copy while a frame runs
  assert_hold_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && !soft_rst_now) |=> $stable(active_q))
    else $error("R2 active config changed mid-frame");

  // R3: pending value lands at the first idle edge
  assert_apply_at_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !frame_active && !soft_rst_now) |=> (active_q == stage_to_act($past(stage_q))))
    else $error("R3 pending config not applied in gap");

  // R5: pulse coincides with restored defaults
  assert_rst_defaults_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |-> (active_q == ACT_DEF && stage_q == STAGE_DEF && !pend_q))
    else $error("R5 defaults not restored with reset pulse");

endmodule

// File: rtl/txcfg_gap.sv
module txcfg_gap #(
  parameter int unsigned IFG_W   = 8,
  parameter int unsigned MIN_IFG = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             frame_active,
  input  logic             gap_ext_en,
  input  logic [IFG_W-1:0] ifg_ext,
  input  logic             tx_en,
  output logic             tx_ready
);

  localparam int unsigned MIN_W = $clog2(MIN_IFG + 1);
  localparam int unsigned CNT_W = (IFG_W > MIN_W) ? IFG_W : MIN_W;
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_IFG);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ext_c;
  logic [CNT_W-1:0] gap_len;

  assign ext_c   = CNT_W'(ifg_ext);
  assign gap_len = (gap_ext_en && ext_c > MIN_C) ? ext_c : MIN_C;

  // Reload during the frame, count idle cycles after it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (frame_active) begin
      cnt_q <= gap_len;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign tx_ready = (cnt_q == '0) && !frame_active && tx_en;

  // R8: a finished frame always leaves at least the minimum gap
  assert_gap_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && !clr) |=> (cnt_q >= MIN_C))
    else $error("R8 gap shorter than minimum");

  // R9: extension is honoured when enabled
  assert_gap_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && !clr && gap_ext_en) |=> (cnt_q >= CNT_W'($past(ifg_ext))))
    else $error("R9 gap shorter than extension");

endmodule

// File: rtl/txcfg_gap_ctrl.sv
module txcfg_gap_ctrl
  import txcfg_pkg::*;
#(
  parameter int unsigned IFG_W   = 8,
  parameter int unsigned MIN_IFG = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  input  logic             reg_rd,
  output logic [31:0]      reg_rdata,
  input  logic             frame_active,
  input  logic [IFG_W-1:0] ifg_ext,
  output logic             cfg_tx_en,
  output logic             cfg_jumbo,
  output logic             cfg_fcs_in,
  output logic             cfg_vlan,
  output logic             tx_rst_pulse,
  output logic             tx_ready
);

  txcfg_act_t act;
  logic       clr_now;

  txcfg_regs u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (reg_wr),
    .wdata          (reg_wdata),
    .rd_en          (reg_rd),
    .frame_active   (frame_active),
    .rdata          (reg_rdata),
    .active         (act),
    .soft_rst_now   (clr_now),
    .soft_rst_pulse (tx_rst_pulse)
  );

  txcfg_gap #(
    .IFG_W   (IFG_W),
    .MIN_IFG (MIN_IFG)
  ) u_gap (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (clr_now),
    .frame_active (frame_active),
    .gap_ext_en   (act.gapx),
    .ifg_ext      (ifg_ext),
    .tx_en        (act.en),
    .tx_ready     (tx_ready)
  );

  assign cfg_tx_en  = act.en;
  assign cfg_jumbo  = act.jumbo;
  assign cfg_fcs_in = act.fcs_in;
  assign cfg_vlan   = act.vlan;

  // R10: disabled transmitter never grants a start
  assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_tx_en |-> !tx_ready)
    else $error("R10 ready while disabled");

  // R5: after a soft reset the gap is cleared and enable restored
  assert_rst_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst_pulse |-> (tx_ready || frame_active))
    else $error("R5 not ready after soft reset");

  // R11: no start permission during a frame
  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_active) |=> (!tx_ready || !frame_active))
    else $error("R11 ready during frame");

endmodule

// File: tb/txcfg_gap_ctrl_tb.sv
module txcfg_gap_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        frame_active = 1'b0;
  logic [7:0]  ifg_ext = '0;
  logic        cfg_tx_en, cfg_jumbo, cfg_fcs_in, cfg_vlan;
  logic        tx_rst_pulse, tx_ready;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txcfg_gap_ctrl u_dut (
    .clk (clk), .rst_n (rst_n),
    .reg_wr (reg_wr), .reg_wdata (reg_wdata),
    .reg_rd (reg_rd), .reg_rdata (reg_rdata),
    .frame_active (frame_active), .ifg_ext (ifg_ext),
    .cfg_tx_en (cfg_tx_en), .cfg_jumbo (cfg_jumbo),
    .cfg_fcs_in (cfg_fcs_in), .cfg_vlan (cfg_vlan),
    .tx_rst_pulse (tx_rst_pulse), .tx_ready (tx_ready)
  );

  // outs = {jumbo, fcs_in, en, vlan}; gap 0 means never ready
  typedef struct packed {
    logic [31:0] wr;
    logic [7:0]  ifg;
    logic [3:0]  outs;
    logic [31:0] rb;
    logic [7:0]  gap;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{32'h1000_0000, 8'd20, 4'b0010, 32'h1000_0000, 8'd12},
    '{32'h7000_0000, 8'd30, 4'b1110, 32'h7000_0000, 8'd12},
    '{32'h1200_0000, 8'd20, 4'b0010, 32'h1200_0000, 8'd20},
    '{32'h1200_0000, 8'd5,  4'b0010, 32'h1200_0000, 8'd12},
    '{32'h1A00_0000, 8'd12, 4'b0011, 32'h1A00_0000, 8'd12},
    '{32'h7FFF_FFFF, 8'd40, 4'b1111, 32'h7E40_0000, 8'd40},
    '{32'h6800_0000, 8'd40, 4'b1101, 32'h6800_0000, 8'd0},
    '{32'h1000_0000, 8'd13, 4'b0010, 32'h1000_0000, 8'd12}
  };

  function automatic logic [3:0] outs();
    return {cfg_jumbo, cfg_fcs_in, cfg_tx_en, cfg_vlan};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; #1;
  endtask

  task automatic do_read(output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; #1;
    d = reg_rdata;
  endtask

  // Called just after frame_active dropped at a falling edge
  task automatic measure_gap(output int n);
    n = 0;
    #1;
    while (!tx_ready && n < 100) begin
      n++;
      @(negedge clk); #1;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [3:0]  prev;
    int          g;

    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 outs", {28'h0, outs()}, {28'h0, 4'b0010});
    chk("R1 rst_pulse", {31'h0, tx_rst_pulse}, 32'h0);
    chk("R1 ready", {31'h0, tx_ready}, 32'h1);
    do_read(rd);
    chk("R1 readback", rd, 32'h1000_0000);

    // Vector table: write mid-frame, then measure a later gap
    prev = 4'b0010;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); ifg_ext = VEC[i].ifg; frame_active = 1'b1;
      do_write(VEC[i].wr);
      chk("R2 held mid-frame", {28'h0, outs()}, {28'h0, prev});
      do_read(rd);
      chk("R7/R6 readback", rd, VEC[i].rb);
      chk("R11 busy", {31'h0, tx_ready}, 32'h0);
      @(negedge clk); frame_active = 1'b0;
      repeat (60) @(negedge clk);
      #1;
      chk("R2 applied after frame", {28'h0, outs()}, {28'h0, VEC[i].outs});
      @(negedge clk); frame_active = 1'b1;
      repeat (2) @(negedge clk);
      frame_active = 1'b0;
      measure_gap(g);
      chk("R8/R9/R10 gap", g, (VEC[i].gap == 0) ? 100 : int'(VEC[i].gap));
      prev = VEC[i].outs;
      repeat (2) @(negedge clk);
    end

    // R3: idle write timing
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 32'h5000_0000;
    @(negedge clk); reg_wr = 1'b0; #1;
    chk("R3 not yet", {31'h0, cfg_jumbo}, 32'h0);
    @(negedge clk); #1;
    chk("R3 applied", {31'h0, cfg_jumbo}, 32'h1);

    // R4: later write replaces pending; R2 exact cycle
    @(negedge clk); frame_active = 1'b1;
    do_write(32'h7000_0000);
    do_write(32'h1800_0000);
    chk("R4 held", {28'h0, outs()}, {28'h0, 4'b1010});
    @(negedge clk); frame_active = 1'b0; #1;
    chk("R2 same cycle", {28'h0, outs()}, {28'h0, 4'b1010});
    @(negedge clk); #1;
    chk("R4 later wins", {28'h0, outs()}, {28'h0, 4'b0011});

    // R5: reset bit acts mid-frame and drops a pending write
    @(negedge clk); frame_active = 1'b1;
    do_write(32'h6000_0000);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 32'h8000_0000;
    @(negedge clk); reg_wr = 1'b0; #1;
    chk("R5 pulse", {31'h0, tx_rst_pulse}, 32'h1);
    chk("R5 defaults now", {28'h0, outs()}, {28'h0, 4'b0010});
    @(negedge clk); #1;
    chk("R5 pulse one cycle", {31'h0, tx_rst_pulse}, 32'h0);
    do_read(rd);
    chk("R5 readback", rd, 32'h1000_0000);
    @(negedge clk); frame_active = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    chk("R5 pending dropped", {28'h0, outs()}, {28'h0, 4'b0010});

    finish_run();
  end

endmodule